// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block is the digital controller of a dual-slope integrating converter. It cycles the analog front end through four phases: auto-zero, signal integrate, deintegrate and, after an overrange result only, a zero-integrator phase. Each phase has its own select output, which drives the analog switch network. The block also drives a reference-sign output for the deintegrate phase. A single comparator input gives the integrator sign. The block samples it at the end of signal integrate to find the input polarity, then watches it during deintegrate for the zero crossing.

A phase timer measures the deintegrate time. On the crossing, the count, the polarity and an overrange flag go into output latches. A busy flag, `status`, rises when a conversion begins integrating and drops half a clock after fresh data lands in the latches, so a host can use its falling edge as a data-valid event. The `run_hold` input stops conversions after the current one finishes, which leaves the sequencer parked in auto-zero.

Top module: `dsq_sequencer`

## Requirements
- R1: Exactly one of `sel_az`, `sel_int`, `sel_deint`, `sel_zi` is high in every cycle. Deintegrate is always entered from signal integrate.
- R2: With `run_hold` high, auto-zero lasts `AZ_CLKS` clocks and is then followed by signal integrate.
- R3: Signal integrate lasts 2^(CNT_W-1) clocks (2048 at the default width).
- R4: `comp_hi` is sampled on the last integrate clock; 1 means positive polarity. During deintegrate, `ref_neg` equals that polarity and is low outside deintegrate.
- R5: The first deintegrate cycle k (counted from 0) in which `comp_hi` differs from the sampled polarity latches `res_count`=k, `res_ovr`=0 and `res_pol`=polarity, then returns to auto-zero.
- R6: If no crossing occurs within 2^CNT_W deintegrate clocks, the latch takes `res_count`=all ones and `res_ovr`=1, and the zero-integrator phase follows.
- R7: The zero-integrator phase occurs only after an overrange result. It ends after the first cycle z in which `comp_hi` differs from the polarity, giving a length of z+1, and it never lasts more than `ZI_MAX` clocks.
- R8: `status` is high from the first clock of signal integrate.
- R9: `status` falls half a clock period after the latch write. The latched outputs never change while `status` is low.
- R10: With `run_hold` low, the running conversion completes and the sequencer then stays in auto-zero with latches unchanged and `status` low. Signal integrate begins on the clock after `run_hold` returns high.
- R11: While `rst_n` is low the block is in auto-zero, `status` is low and all latched outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_hold | input | 1 | 1 = convert continuously, 0 = park in auto-zero after the current conversion |
| comp_hi | input | 1 | Comparator output, 1 = integrator on the positive side |
| sel_az | output | 1 | Auto-zero switch select |
| sel_int | output | 1 | Signal-integrate switch select |
| sel_deint | output | 1 | Deintegrate switch select |
| sel_zi | output | 1 | Zero-integrator switch select |
| ref_neg | output | 1 | Deintegrate with the negative reference |
| status | output | 1 | Conversion busy / data-valid flag |
| res_count | output | CNT_W | Latched deintegrate count |
| res_pol | output | 1 | Latched polarity, 1 = positive |
| res_ovr | output | 1 | Latched overrange flag |

## Verification
The bench builds the sequencer with `CNT_W`=4, `AZ_CLKS`=3 and `ZI_MAX`=4. At these values the integrate phase is 8 clocks and overrange comes after 16 deintegrate clocks, so the full-scale count, a crossing on the very last deintegrate clock and the cap on the zero-integrator phase can all be reached in a few dozen cycles each. The small `ZI_MAX` also allows an early exit from the zero-integrator phase to be compared with a capped one, and both polarities can be run back to back between hold and resume.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2,
    PH_ZI    = 2'd3
  } phase_e;

  // integrator has passed zero once the comparator disagrees with the sampled sign
  function automatic logic sign_flipped(input logic comp, input logic pol);
    return comp != pol;
  endfunction

  // number of signal-integrate clocks for a given counter width
  function automatic int integ_clocks(input int w);
    return 2 ** (w - 1);
  endfunction
endpackage

// File: rtl/dsq_phase_timer.sv
module dsq_phase_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dsq_result_latch.sv
module dsq_result_latch #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] cnt_in,
  input  logic         pol_in,
  input  logic         ovr_in,
  output logic [W-1:0] cnt_q,
  output logic         pol_q,
  output logic         ovr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
      ovr_q <= 1'b0;
    end else if (wr) begin
      cnt_q <= cnt_in;
      pol_q <= pol_in;
      ovr_q <= ovr_in;
    end
  end
endmodule

// File: rtl/dsq_status_gen.sv
module dsq_status_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic status
);
  logic busy_p;
  logic busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   busy_p <= 1'b0;
    else if (set) busy_p <= 1'b1;
    else if (clr) busy_p <= 1'b0;
  end

  // falling-edge copy stretches the drop by half a period
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) busy_n <= 1'b0;
    else        busy_n <= busy_p;
  end

  assign status = busy_p | busy_n;
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int AZ_CLKS = 1024,
  parameter int ZI_MAX  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_hold,
  input  logic             comp_hi,
  output logic             sel_az,
  output logic             sel_int,
  output logic             sel_deint,
  output logic             sel_zi,
  output logic             ref_neg,
  output logic             status,
  output logic [CNT_W-1:0] res_count,
  output logic             res_pol,
  output logic             res_ovr
);
  localparam logic [CNT_W-1:0] AZ_LAST    = CNT_W'(AZ_CLKS - 1);
  localparam logic [CNT_W-1:0] INT_LAST   = CNT_W'(integ_clocks(CNT_W) - 1);
  localparam logic [CNT_W-1:0] ZI_LAST    = CNT_W'(ZI_MAX - 1);
  localparam logic [CNT_W-1:0] DEINT_LAST = '1;

  phase_e           ph, ph_nx;
  logic [CNT_W-1:0] t;
  logic             t_clr, t_en;
  logic             pol_q;
  logic             crossed;
  logic             lat_wr, lat_ovr, conv_start;

  assign crossed = sign_flipped(comp_hi, pol_q);

  always_comb begin
    ph_nx      = ph;
    t_clr      = 1'b0;
    t_en       = 1'b1;
    lat_wr     = 1'b0;
    lat_ovr    = 1'b0;
    conv_start = 1'b0;
    case (ph)
      PH_AZ: if (t == AZ_LAST) begin
        t_en = 1'b0;
        if (run_hold) begin
          ph_nx      = PH_INT;
          t_clr      = 1'b1;
          conv_start = 1'b1;
        end
      end
      PH_INT: if (t == INT_LAST) begin
        ph_nx = PH_DEINT;
        t_clr = 1'b1;
      end
      PH_DEINT: if (crossed) begin
        lat_wr = 1'b1;
        ph_nx  = PH_AZ;
        t_clr  = 1'b1;
      end else if (t == DEINT_LAST) begin
        lat_wr  = 1'b1;
        lat_ovr = 1'b1;
        ph_nx   = PH_ZI;
        t_clr   = 1'b1;
      end
      PH_ZI: if (crossed || t == ZI_LAST) begin
        ph_nx = PH_AZ;
        t_clr = 1'b1;
      end
      default: ph_nx = PH_AZ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_AZ;
      pol_q <= 1'b0;
    end else begin
      ph <= ph_nx;
      if (ph == PH_INT && t == INT_LAST) pol_q <= comp_hi;
    end
  end

  dsq_phase_timer #(.W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .en(t_en), .cnt(t)
  );

  dsq_result_latch #(.W(CNT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(lat_wr),
    .cnt_in(lat_ovr ? DEINT_LAST : t), .pol_in(pol_q), .ovr_in(lat_ovr),
    .cnt_q(res_count), .pol_q(res_pol), .ovr_q(res_ovr)
  );

  dsq_status_gen u_status (
    .clk(clk), .rst_n(rst_n), .set(conv_start), .clr(lat_wr), .status(status)
  );

  assign sel_az    = (ph == PH_AZ);
  assign sel_int   = (ph == PH_INT);
  assign sel_deint = (ph == PH_DEINT);
  assign sel_zi    = (ph == PH_ZI);
  assign ref_neg   = sel_deint & pol_q;
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int CNT_W  = 12,
  parameter int ZI_MAX = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_hold,
  input logic             sel_az,
  input logic             sel_int,
  input logic             sel_deint,
  input logic             sel_zi,
  input logic             ref_neg,
  input logic             status,
  input logic [CNT_W-1:0] res_count,
  input logic             res_pol,
  input logic             res_ovr
);
  int zi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      zi_run <= 0;
    else if (sel_zi) zi_run <= zi_run + 1;
    else             zi_run <= 0;
  end

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_az, sel_int, sel_deint, sel_zi}) == 1);

  assert_deint_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_deint) |-> $past(sel_int));

  assert_ref_only_deint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_neg |-> sel_deint);

  assert_full_scale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_zi) |-> (res_ovr && res_count == '1));

  assert_zi_after_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_zi |-> res_ovr);

  assert_zi_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zi_run <= ZI_MAX);

  assert_status_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_int) |-> status);

  assert_latch_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !status |=> $stable({res_count, res_pol, res_ovr}));

  assert_hold_parks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_az && !run_hold) |=> !sel_int);
endmodule

bind dsq_sequencer dsq_checker #(.CNT_W(CNT_W), .ZI_MAX(ZI_MAX)) u_dsq_checker (
  .clk(clk), .rst_n(rst_n), .run_hold(run_hold),
  .sel_az(sel_az), .sel_int(sel_int), .sel_deint(sel_deint), .sel_zi(sel_zi),
  .ref_neg(ref_neg), .status(status),
  .res_count(res_count), .res_pol(res_pol), .res_ovr(res_ovr)
);

// File: tb/test_dsq_sequencer.sv
module test_dsq_sequencer;
  localparam int CNT_W   = 4;
  localparam int AZ_CLKS = 3;
  localparam int ZI_MAX  = 4;
  localparam int INT_LEN = 2 ** (CNT_W - 1);
  localparam int FULL    = 2 ** CNT_W - 1;
  localparam int NV      = 8;

  // pol, crossing cycle k, ZI crossing cycle z, exp count, exp ovr, exp ZI length
  localparam int VT [NV][6] = '{
    '{1,  5, 0,  5, 0, 0},
    '{0,  9, 0,  9, 0, 0},
    '{1,  0, 0,  0, 0, 0},
    '{0, 15, 0, 15, 0, 0},
    '{1, 20, 1, 15, 1, 2},
    '{0, 20, 9, 15, 1, 4},
    '{1, 16, 0, 15, 1, 1},
    '{0,  3, 0,  3, 0, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_hold = 1'b1;
  logic comp_hi = 1'b0;
  logic sel_az, sel_int, sel_deint, sel_zi, ref_neg, status;
  logic [CNT_W-1:0] res_count;
  logic res_pol, res_ovr;

  int checks = 0;
  int errors = 0;
  int az_seen = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dsq_sequencer #(.CNT_W(CNT_W), .AZ_CLKS(AZ_CLKS), .ZI_MAX(ZI_MAX)) i_dsq_sequencer (
    .clk(clk), .rst_n(rst_n), .run_hold(run_hold), .comp_hi(comp_hi),
    .sel_az(sel_az), .sel_int(sel_int), .sel_deint(sel_deint), .sel_zi(sel_zi),
    .ref_neg(ref_neg), .status(status),
    .res_count(res_count), .res_pol(res_pol), .res_ovr(res_ovr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One conversion, started from an auto-zero or integrate cycle.
  task automatic run_conv(input int pol, input int k, input int zk, input bit drop_hold,
                          output int az_len, output int int_len, output int zi_len,
                          output bit ref_ok, output bit st_hi, output bit st_lo);
    int  dj = 0;
    bit  seen_deint = 1'b0;
    bit  exit_seen = 1'b0;
    az_len = az_seen; int_len = 0; zi_len = 0; ref_ok = 1'b1; st_hi = 1'b0; st_lo = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (seen_deint && !sel_deint && !exit_seen) begin
        exit_seen = 1'b1;
        st_hi = status;
        #2 st_lo = status;
      end
      if (sel_az) begin
        if (seen_deint) begin az_seen = 1; break; end
        az_len++;
        comp_hi = pol[0];
      end else if (sel_int) begin
        if (drop_hold) run_hold = 1'b0;
        int_len++;
        comp_hi = pol[0];
      end else if (sel_deint) begin
        seen_deint = 1'b1;
        if (ref_neg !== pol[0]) ref_ok = 1'b0;
        comp_hi = (dj >= k) ? ~pol[0] : pol[0];
        dj++;
      end else begin
        comp_hi = (zi_len >= zk) ? ~pol[0] : pol[0];
        zi_len++;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int az_l, int_l, zi_l;
    bit ref_ok, st_hi, st_lo;
    logic [CNT_W+1:0] snap;

    // R11 reset values
    repeat (3) @(posedge clk);
    #1;
    chk(sel_az && !sel_int && !sel_deint && !sel_zi, "R11 phase in reset", sel_az, 1);
    chk(status == 1'b0, "R11 status in reset", status, 0);
    chk(res_count == '0 && !res_pol && !res_ovr, "R11 latches in reset", res_count, 0);
    rst_n = 1'b1;
    az_seen = 1;

    for (int i = 0; i < NV; i++) begin
      run_conv(VT[i][0], VT[i][1], VT[i][2], 1'b0, az_l, int_l, zi_l, ref_ok, st_hi, st_lo);
      chk(az_l == AZ_CLKS, "R2 auto-zero length", az_l, AZ_CLKS);
      chk(int_l == INT_LEN, "R3 integrate length", int_l, INT_LEN);
      chk(ref_ok, "R4 ref_neg during deintegrate", ref_ok, 1);
      chk(int'(res_pol) == VT[i][0], "R5 latched polarity", res_pol, VT[i][0]);
      chk(int'(res_count) == VT[i][3], "R5/R6 latched count", res_count, VT[i][3]);
      chk(int'(res_ovr) == VT[i][4], "R6 overrange flag", res_ovr, VT[i][4]);
      chk(zi_l == VT[i][5], "R7 zero-integrator length", zi_l, VT[i][5]);
      chk(st_hi && !st_lo, "R9 status half-clock fall", {st_hi, st_lo}, 2);
    end

    // R10 hold: drop run_hold during integrate, conversion still completes
    run_conv(1, 7, 0, 1'b1, az_l, int_l, zi_l, ref_ok, st_hi, st_lo);
    chk(int'(res_count) == 7 && !res_ovr, "R10 held conversion completes", res_count, 7);
    snap = {res_count, res_pol, res_ovr};
    begin
      bit parked = 1'b1;
      for (int c = 0; c < 30; c++) begin
        @(posedge clk); #1;
        comp_hi = ~comp_hi;
        if (!sel_az || status || {res_count, res_pol, res_ovr} != snap) parked = 1'b0;
      end
      chk(parked, "R10 parked in auto-zero", parked, 1);
    end
    run_hold = 1'b1;
    @(posedge clk); #1;
    chk(sel_int, "R10 resume into integrate", sel_int, 1);
    chk(status, "R8 status high on first integrate clock", status, 1);
    comp_hi = 1'b0;
    az_seen = 0;
    run_conv(0, 2, 0, 1'b0, az_l, int_l, zi_l, ref_ok, st_hi, st_lo);
    chk(int_l == INT_LEN - 1 && int'(res_count) == 2 && !res_pol, "R10 conversion after resume",
        res_count, 2);

    // R8 status rises with integrate on a fresh conversion
    begin
      bit rose_ok = 1'b0;
      for (int c = 0; c < 10; c++) begin
        @(posedge clk); #1;
        if (sel_int) begin rose_ok = status; break; end
        if (status) break;
      end
      chk(rose_ok, "R8 status with first integrate cycle", rose_ok, 1);
    end

    // R11 reset in the middle of a conversion
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(sel_az && !status && res_count == '0 && !res_ovr && !res_pol,
        "R11 asynchronous reset mid-conversion", res_count, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule